// File: doc/BRIEF.md
# Successive-Approximation Conversion Register with Output Coding

This block is the digital half of a serial-clocked successive-approximation converter. A falling edge on the active-low select input starts a conversion. The block then counts falling edges of the serial clock. The first three falling edges are left to the external track-and-hold for acquisition. From the fourth falling edge through the eleventh, the block resolves one bit per edge, most significant bit first. It places the trial code on `dac_code` for an external DAC and comparator, and it reads one comparator decision `cmp_ge` on each deciding edge.

Each decided bit appears on `bit_out` in the same cycle as its decision, so a serial shifter can send it straight out. The block has two codings, picked by a mode pin that it latches once per conversion. The unipolar coding is straight binary. The bipolar coding is two's complement, which the block forms by inverting the most significant bit of the offset-binary search result. When the last bit settles, `done` pulses for one cycle, and the coded word stays on `result` until the next conversion completes.

The serial clock and the select input are sampled in the `clk` domain. Every edge event acts on the `clk` edge that first sees the new level.

Top module: `sar_conv_core`

## Requirements
- R1: After reset, `busy`, `done` and `bit_valid` are 0, `result` is 0x00 and `dac_code` is 0x80.
- R2: A falling edge of `cs_n` seen while idle starts a conversion. On the next clock, `busy` is 1 and `dac_code` is 0x80 (only the top bit set).
- R3: `mode_uni` (1 = unipolar, 0 = bipolar) is captured on the first rising edge of `sclk` after the start. Later changes of the pin have no effect on that conversion.
- R4: The first three falling edges of `sclk` after the start make no decision, and `bit_valid` stays 0 for them.
- R5: The most significant bit is decided on the 4th falling edge of `sclk`, and the next lower bit on each later falling edge. The least significant bit is decided on the 11th falling edge. Each decision raises `bit_valid` for one cycle, with the coded bit on `bit_out`, one clock after the edge is sampled.
- R6: On each decision, the bit under test in the trial code is kept when `cmp_ge` is 1 and cleared when it is 0, and the next lower bit is set. So after the 4th falling edge, `dac_code` is 0xC0 when `cmp_ge` was 1 and 0x40 when it was 0.
- R7: In unipolar mode, `result` and the serial bits equal the offset-binary search result in straight binary (0x00 at zero scale, 0xFF at full scale).
- R8: In bipolar mode, the MSB of the search result is inverted on both `result` and the first serial bit. This gives 0x80 at negative full scale, 0x00 at mid scale and 0x7F at positive full scale.
- R9: `done` is high for exactly one cycle, together with the last `bit_valid`, and `busy` is 0 from then on. Further `sclk` falling edges make no decision, and `result` holds until the next conversion completes.
- R10: A `cs_n` falling edge while busy is ignored, including one sampled in the same cycle as the 11th `sclk` falling edge. Raising `cs_n` during a conversion does not stop it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; its falling edge starts a conversion |
| sclk | input | 1 | Serial clock; falling edges step the conversion |
| mode_uni | input | 1 | Coding select: 1 unipolar straight binary, 0 bipolar two's complement |
| cmp_ge | input | 1 | Comparator decision: 1 when the held input is at or above the DAC level |
| dac_code | output | 8 | Trial code, in offset binary, driven to the external DAC |
| bit_out | output | 1 | Most recently decided bit, coded per the latched mode |
| bit_valid | output | 1 | One-cycle pulse marking a fresh decision on `bit_out` |
| done | output | 1 | One-cycle pulse when the final bit is decided |
| busy | output | 1 | High from start until the final decision |
| result | output | 8 | Coded conversion word of the last completed conversion |

## Verification
Two events can fall in the same sampled cycle: the 11th `sclk` falling edge, which ends the conversion, and a new `cs_n` falling edge, which is the continuous-conversion pattern. The bench drives both edges on the same clock. It then expects the finishing conversion to deliver its last bit and its `done` pulse, with `busy` left at 0, and it expects no new conversion to start. It judges this by checking that a following burst of `sclk` edges produces no `bit_valid`, and that `result` keeps the finished word.

// File: rtl/sar_conv_pkg.sv
package sar_conv_pkg;
  // Value of the coding pin, as sampled at the first serial-clock rise.
  typedef enum logic {
    CODING_BIPOLAR  = 1'b0,
    CODING_UNIPOLAR = 1'b1
  } coding_e;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
  parameter bit IDLE_LEVEL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= IDLE_LEVEL;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;
endmodule

// File: rtl/sar_step_seq.sv
module sar_step_seq #(
  parameter int W   = 8,
  parameter int ACQ = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 sclk_fall,
  output logic                 busy,
  output logic                 step_en,
  output logic                 last_step,
  output logic [$clog2(W)-1:0] bit_idx
);
  localparam int LAST = ACQ + W;
  localparam int CW   = $clog2(LAST + 1);
  localparam int IW   = $clog2(W);

  logic [CW-1:0] edge_cnt;
  logic [CW-1:0] dec_off;

  assign dec_off   = edge_cnt - CW'(ACQ);
  assign step_en   = busy & sclk_fall & (edge_cnt >= CW'(ACQ));
  assign last_step = step_en & (edge_cnt == CW'(LAST - 1));
  assign bit_idx   = IW'(W - 1) - IW'(dec_off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      edge_cnt <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      edge_cnt <= '0;
    end else if (busy && sclk_fall) begin
      edge_cnt <= edge_cnt + 1'b1;
      if (edge_cnt == CW'(LAST - 1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg #(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 step_en,
  input  logic [$clog2(W)-1:0] bit_idx,
  input  logic                 cmp_ge,
  output logic [W-1:0]         trial,
  output logic [W-1:0]         trial_nxt
);
  localparam logic [W-1:0] SEED = {1'b1, {(W-1){1'b0}}};

  // Keep or clear the bit under test, then arm the next lower bit.
  function automatic logic [W-1:0] resolve(input logic [W-1:0] cur,
                                           input int idx, input logic keep);
    logic [W-1:0] n;
    n = cur;
    n[idx] = keep;
    if (idx > 0) n[idx-1] = 1'b1;
    return n;
  endfunction

  assign trial_nxt = resolve(trial, int'(bit_idx), cmp_ge);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       trial <= SEED;
    else if (start)   trial <= SEED;
    else if (step_en) trial <= trial_nxt;
  end
endmodule

// File: rtl/sar_conv_core.sv
module sar_conv_core
  import sar_conv_pkg::*;
#(
  parameter int W   = 8,
  parameter int ACQ = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         sclk,
  input  logic         mode_uni,
  input  logic         cmp_ge,
  output logic [W-1:0] dac_code,
  output logic         bit_out,
  output logic         bit_valid,
  output logic         done,
  output logic         busy,
  output logic [W-1:0] result
);
  localparam int IW = $clog2(W);

  logic          sclk_rise, sclk_fall, cs_rise, cs_fall;
  logic          start_evt, step_en, last_step, mode_latch_evt, rise_pending;
  logic [IW-1:0] bit_idx;
  logic [W-1:0]  trial_nxt;
  coding_e       mode_q;

  // Straight binary passes through; two's complement flips the top bit.
  function automatic logic [W-1:0] apply_coding(input logic [W-1:0] v,
                                                input coding_e m);
    return (m == CODING_UNIPOLAR) ? v : {~v[W-1], v[W-2:0]};
  endfunction

  sar_edge_det #(.IDLE_LEVEL(1'b0)) u_sclk_ed (
    .clk(clk), .rst_n(rst_n), .din(sclk), .rise(sclk_rise), .fall(sclk_fall));

  sar_edge_det #(.IDLE_LEVEL(1'b1)) u_cs_ed (
    .clk(clk), .rst_n(rst_n), .din(cs_n), .rise(cs_rise), .fall(cs_fall));

  assign start_evt      = cs_fall & ~busy;
  assign mode_latch_evt = busy & rise_pending & sclk_rise;

  sar_step_seq #(.W(W), .ACQ(ACQ)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .sclk_fall(sclk_fall),
    .busy(busy), .step_en(step_en), .last_step(last_step), .bit_idx(bit_idx));

  sar_trial_reg #(.W(W)) u_trial (
    .clk(clk), .rst_n(rst_n), .start(start_evt), .step_en(step_en),
    .bit_idx(bit_idx), .cmp_ge(cmp_ge), .trial(dac_code), .trial_nxt(trial_nxt));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_pending <= 1'b0;
      mode_q       <= CODING_UNIPOLAR;
    end else if (start_evt) begin
      rise_pending <= 1'b1;
    end else if (mode_latch_evt) begin
      rise_pending <= 1'b0;
      mode_q       <= coding_e'(mode_uni);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
      done      <= 1'b0;
      result    <= '0;
    end else begin
      bit_valid <= step_en;
      done      <= last_step;
      if (step_en)
        bit_out <= (bit_idx == IW'(W - 1) && mode_q == CODING_BIPOLAR) ? ~cmp_ge : cmp_ge;
      if (last_step)
        result <= apply_coding(trial_nxt, mode_q);
    end
  end

  // cs_rise is observed only so that a raised select is known to be harmless.
  logic unused_ok;
  assign unused_ok = cs_rise;
endmodule

// File: rtl/sar_conv_chk.sv
module sar_conv_chk
  import sar_conv_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start_evt,
  input logic         step_en,
  input logic         last_step,
  input logic         mode_latch_evt,
  input logic         cs_fall,
  input logic         busy,
  input logic         done,
  input logic         bit_valid,
  input logic [W-1:0] dac_code,
  input logic [W-1:0] result,
  input coding_e      mode_q
);
  assert_trial_seed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (dac_code == {1'b1, {(W-1){1'b0}}}));

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  assert_mode_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_latch_evt |=> $stable(mode_q));

  assert_done_with_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bit_valid);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_idle_at_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_no_idle_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !step_en);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !last_step |=> $stable(result));

  assert_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_fall) |-> !start_evt);

  assert_keeps_running_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_step) |=> busy);
endmodule

bind sar_conv_core sar_conv_chk #(.W(W)) u_chk (.*);

// File: tb/sim_sar_conv_core.sv
module sim_sar_conv_core;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sclk = 1'b0;
  logic       mode_uni = 1'b1;
  logic       cmp_ge;
  logic [7:0] vin = 8'h00;
  logic [7:0] dac_code, result;
  logic       bit_out, bit_valid, done, busy;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  logic  exp_bits[$];
  string exp_btag[$];
  logic [7:0] exp_res[$];
  string exp_rtag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // Ideal comparator: held level against the trial code, both offset binary.
  assign cmp_ge = (vin >= dac_code);

  sar_conv_core u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mode_uni(mode_uni),
    .cmp_ge(cmp_ge), .dac_code(dac_code), .bit_out(bit_out),
    .bit_valid(bit_valid), .done(done), .busy(busy), .result(result));

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Monitor: pops expected bits and words as the design produces them.
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_valid) begin
        if (exp_bits.size() == 0)
          check(1'b0, "R4/R9", "unexpected bit_valid", 1, 0);
        else begin
          logic  eb;
          string et;
          eb = exp_bits.pop_front();
          et = exp_btag.pop_front();
          check(bit_out === eb, et, "serial bit", int'(bit_out), int'(eb));
        end
      end
      if (done) begin
        if (exp_res.size() == 0)
          check(1'b0, "R9", "unexpected done", 1, 0);
        else begin
          logic [7:0] er;
          string      rt;
          er = exp_res.pop_front();
          rt = exp_rtag.pop_front();
          check(result === er, rt, "result word", int'(result), int'(er));
        end
      end
    end
  end

  // Driver: one conversion. Variant 0 plain, 1 mode flip after the first rise,
  // 2 select glitch mid-conversion, 3 new select fall on the 11th falling edge.
  task automatic convert(input bit uni, input logic [7:0] lvl, input int variant);
    logic [7:0] code;
    string      tag;
    code = uni ? lvl : (lvl ^ 8'h80);
    tag  = uni ? "R7" : "R8";
    for (int i = 7; i >= 0; i--) begin
      exp_bits.push_back(code[i]);
      exp_btag.push_back(i == 7 ? {"R5/", tag} : "R5/R6");
    end
    exp_res.push_back(code);
    exp_rtag.push_back(tag);

    @(negedge clk);
    vin = lvl;
    mode_uni = uni;
    cs_n = 1'b0;
    @(negedge clk);
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    check(dac_code === 8'h80, "R2", "seed trial", int'(dac_code), 8'h80);
    for (int e = 1; e <= 11; e++) begin
      sclk = 1'b1;
      @(negedge clk);
      if (variant == 1 && e == 1) mode_uni = ~uni;   // R3: must be ignored
      if (variant == 2 && e == 5) cs_n = 1'b1;        // R10
      @(negedge clk);
      sclk = 1'b0;
      if (variant == 2 && e == 6) cs_n = 1'b0;        // R10: ignored restart
      if (variant == 3 && e == 10) cs_n = 1'b1;
      if (variant == 3 && e == 11) cs_n = 1'b0;       // coincides with last edge
      @(negedge clk);
      if (e == 4)
        check(dac_code === ((lvl >= 8'h80) ? 8'hC0 : 8'h40), "R6", "trial after MSB",
              int'(dac_code), (lvl >= 8'h80) ? 8'hC0 : 8'h40);
      @(negedge clk);
    end
    check(busy === 1'b0, "R9", "idle after LSB", int'(busy), 0);
    // Extra serial edges: no decision, word held (R9; for variant 3 also R10).
    for (int k = 0; k < 3; k++) begin
      sclk = 1'b1;
      repeat (2) @(negedge clk);
      sclk = 1'b0;
      repeat (2) @(negedge clk);
    end
    check(busy === 1'b0, variant == 3 ? "R10" : "R9", "still idle", int'(busy), 0);
    check(result === code, "R9", "result held", int'(result), int'(code));
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1", "reset busy", int'(busy), 0);
    check(done === 1'b0, "R1", "reset done", int'(done), 0);
    check(bit_valid === 1'b0, "R1", "reset bit_valid", int'(bit_valid), 0);
    check(result === 8'h00, "R1", "reset result", int'(result), 0);
    check(dac_code === 8'h80, "R1", "reset trial", int'(dac_code), 8'h80);

    convert(1'b1, 8'h00, 0);   // R7 zero scale
    convert(1'b1, 8'hFF, 0);   // R7 full scale
    convert(1'b1, 8'h5A, 0);
    convert(1'b1, 8'h80, 0);
    convert(1'b0, 8'h00, 0);   // R8 negative full scale -> 0x80
    convert(1'b0, 8'h80, 0);   // R8 mid scale -> 0x00
    convert(1'b0, 8'hFF, 0);   // R8 positive full scale -> 0x7F
    convert(1'b0, 8'h3C, 0);
    convert(1'b0, 8'hC7, 1);   // R3 late mode change ignored
    convert(1'b1, 8'hA5, 1);
    convert(1'b1, 8'h33, 2);   // R10 select glitch
    convert(1'b0, 8'h61, 3);   // R10 coincident restart

    check(exp_bits.size() == 0, "R5", "missing bits", exp_bits.size(), 0);
    check(exp_res.size() == 0, "R9", "missing done", exp_res.size(), 0);
    finished = 1;
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      report();
    end
  end
endmodule